// File: doc/BRIEF.md
# IDE DMA Transfer Sequencer

This block steers one DMA command between a drive model and a descriptor-driven DMA channel. A start pulse loads the byte total and clears the progress index. The total is the sector count times 512 for a disk, or the packet size for an optical target. The start pulse also sets an internal active flag and kicks the channel. Every descriptor chunk that the channel then presents gets one of these outcomes:

- a park, when the drive is not yet active;
- an immediate finish, when nothing remains;
- an empty-chunk acknowledge;
- a direct buffer copy, for optical non-block data;
- an illegal-command flag;
- a storage request.

A storage request carries a byte offset built from the latched block address and the progress index. The shift is 9 for a disk and 11 for an optical target. The request stays presented until storage answers. An answer either closes the chunk or completes the command. Completion sets the drive status and pulses an interrupt. An error answer reports a drive error.

Top module: `ide_dma_seq`

## Requirements
- R1: After a start pulse, when no storage request is outstanding, `kick` pulses for one cycle and `active` goes to 1. The byte total is `sector_cnt`*512 for a disk or `pkt_size` for an optical target. The progress index restarts at 0. `sector_lba`, `cmd` and `is_optical` are latched at the same edge.
- R2: A chunk presented while `active` is 0 pulses `chunk_park`. It gives no `chunk_done`, no request and no interrupt.
- R3: A chunk of length 0, presented while active with bytes remaining, pulses `chunk_done` only. `active` stays 1 and no interrupt is raised.
- R4: A disk request presents `req_offset` = `sector_lba`*512 + progress index and `req_len` = the chunk length. The index then grows by the chunk length. The request holds with a stable offset and operation until `req_ack`.
- R5: An optical request presents `req_offset` = `sector_lba`*2048 + progress index, with `req_op` = 0 (read).
- R6: Disk `cmd` codes are 0 for read, 1 for write and 2 for trim, and each is copied to `req_op`. Code 3 pulses `cmd_illegal` and `chunk_done`, issues no request and clears `active`.
- R7: `req_ack` without `req_err` pulses `chunk_done`. If the remaining count is then zero or negative, the same cycle also sets `drv_status` to 8'h50 (ready with seek complete), pulses `irq` and clears `active`.
- R8: `req_ack` with `req_err` pulses `drv_err`, `irq` and `chunk_done`, sets `drv_status` to 8'h51 and clears `active`.
- R9: A chunk presented while active with zero or fewer bytes remaining completes the command. It sets status 8'h50, pulses `irq` and `chunk_done`, clears `active` and issues no request.
- R10: On an optical target whose latched block address is all ones, a chunk pulses `copy_valid` with `copy_len` equal to the smaller of the remaining count and the chunk length. It then completes as in R9, without a storage request.
- R11: A start pulse while a request is outstanding is ignored. A start and a chunk in the same cycle let the chunk be judged against the active flag from before that edge, while the start still takes effect.
- R12: After reset all outputs are 0 and `drv_status` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a command |
| is_optical | input | 1 | Target is an optical drive |
| cmd | input | 2 | Disk operation code |
| sector_lba | input | LBA_W | Starting sector or block address |
| sector_cnt | input | CNT_W | Disk sector count |
| pkt_size | input | SIZE_W | Optical transfer size in bytes |
| kick | output | 1 | Channel kick pulse |
| active | output | 1 | DMA-active flag |
| chunk_valid | input | 1 | Descriptor chunk presented |
| chunk_len | input | LEN_W | Remaining descriptor length |
| chunk_done | output | 1 | Chunk finished pulse |
| chunk_park | output | 1 | Chunk parked, waiting for restart |
| req_valid | output | 1 | Storage request pending |
| req_op | output | 2 | Storage operation |
| req_offset | output | LBA_W+12 | Storage byte offset |
| req_len | output | LEN_W | Storage byte length |
| req_ack | input | 1 | Storage completion |
| req_err | input | 1 | Storage completion with error |
| copy_valid | output | 1 | Direct buffer copy pulse |
| copy_len | output | LEN_W | Bytes copied directly |
| drv_status | output | 8 | Drive status byte |
| irq | output | 1 | Interrupt pulse |
| drv_err | output | 1 | Drive error pulse |
| cmd_illegal | output | 1 | Illegal command pulse |

## Verification
A start pulse and a chunk arrival can land on the same clock edge. The start loads the active flag, while the chunk must be judged by that flag as it stood before the edge. The bench raises both inputs together from an inactive state. It expects a park and a kick in the same cycle, with `active` reading 1 afterward. It also issues a second start while a request is pending and confirms that the completion follows the original byte total.

// File: rtl/ide_dma_seq.sv
module ide_dma_seq #(
  parameter int LBA_W  = 32,
  parameter int CNT_W  = 16,
  parameter int SIZE_W = 28,
  parameter int LEN_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               is_optical,
  input  logic [1:0]         cmd,
  input  logic [LBA_W-1:0]   sector_lba,
  input  logic [CNT_W-1:0]   sector_cnt,
  input  logic [SIZE_W-1:0]  pkt_size,
  output logic               kick,
  output logic               active,
  input  logic               chunk_valid,
  input  logic [LEN_W-1:0]   chunk_len,
  output logic               chunk_done,
  output logic               chunk_park,
  output logic               req_valid,
  output logic [1:0]         req_op,
  output logic [LBA_W+11:0]  req_offset,
  output logic [LEN_W-1:0]   req_len,
  input  logic               req_ack,
  input  logic               req_err,
  output logic               copy_valid,
  output logic [LEN_W-1:0]   copy_len,
  output logic [7:0]         drv_status,
  output logic               irq,
  output logic               drv_err,
  output logic               cmd_illegal
);
  localparam int OFF_W = LBA_W + 12;
  localparam int REM_W = SIZE_W + 1;
  localparam logic [7:0] ST_OK  = 8'h50;
  localparam logic [7:0] ST_ERR = 8'h51;
  localparam logic [1:0] OP_BAD = 2'd3;

  logic                    busy, opt_q;
  logic [1:0]              cmd_q;
  logic [LBA_W-1:0]        lba_q;
  logic signed [REM_W-1:0] remain;
  logic [SIZE_W-1:0]       index;

  wire [SIZE_W-1:0]       disk_size = {{(SIZE_W-CNT_W-9){1'b0}}, sector_cnt, 9'b0};
  wire [SIZE_W-1:0]       load_size = is_optical ? pkt_size : disk_size;
  wire signed [REM_W-1:0] len_s     = $signed({{(REM_W-LEN_W){1'b0}}, chunk_len});
  wire                    nothing_left = (remain <= 0);
  wire [OFF_W-1:0]        base_off  = opt_q ? {{(OFF_W-LBA_W-11){1'b0}}, lba_q, 11'b0}
                                            : {{(OFF_W-LBA_W-9){1'b0}}, lba_q, 9'b0};
  wire [OFF_W-1:0]        next_off  = base_off + {{(OFF_W-SIZE_W){1'b0}}, index};
  wire [LEN_W-1:0]        cap_len   = (remain < len_s) ? remain[LEN_W-1:0] : chunk_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; active <= 1'b0; opt_q <= 1'b0; cmd_q <= '0; lba_q <= '0;
      remain <= '0; index <= '0;
      kick <= 1'b0; chunk_done <= 1'b0; chunk_park <= 1'b0;
      req_valid <= 1'b0; req_op <= '0; req_offset <= '0; req_len <= '0;
      copy_valid <= 1'b0; copy_len <= '0; drv_status <= '0;
      irq <= 1'b0; drv_err <= 1'b0; cmd_illegal <= 1'b0;
    end else begin
      kick <= 1'b0; chunk_done <= 1'b0; chunk_park <= 1'b0; copy_valid <= 1'b0;
      irq <= 1'b0; drv_err <= 1'b0; cmd_illegal <= 1'b0;
      if (busy) begin
        if (req_ack) begin
          busy <= 1'b0;
          req_valid <= 1'b0;
          chunk_done <= 1'b1;
          if (req_err) begin
            drv_err <= 1'b1; drv_status <= ST_ERR; irq <= 1'b1; active <= 1'b0;
          end else if (nothing_left) begin
            drv_status <= ST_OK; irq <= 1'b1; active <= 1'b0;
          end
        end
      end else if (chunk_valid) begin
        if (!active) begin
          chunk_park <= 1'b1;
        end else if (nothing_left) begin
          drv_status <= ST_OK; irq <= 1'b1; active <= 1'b0; chunk_done <= 1'b1;
        end else if (chunk_len == '0) begin
          chunk_done <= 1'b1;
        end else if (opt_q && (&lba_q)) begin
          copy_valid <= 1'b1; copy_len <= cap_len;
          drv_status <= ST_OK; irq <= 1'b1; active <= 1'b0; chunk_done <= 1'b1;
        end else if (!opt_q && cmd_q == OP_BAD) begin
          cmd_illegal <= 1'b1; chunk_done <= 1'b1; active <= 1'b0;
        end else begin
          busy <= 1'b1;
          req_valid <= 1'b1;
          req_op <= opt_q ? 2'd0 : cmd_q;
          req_offset <= next_off;
          req_len <= chunk_len;
          remain <= remain - len_s;
          index <= index + SIZE_W'(chunk_len);
        end
      end
      if (start && !busy) begin
        active <= 1'b1;
        kick <= 1'b1;
        remain <= $signed({1'b0, load_size});
        index <= '0;
        opt_q <= is_optical;
        cmd_q <= cmd;
        lba_q <= sector_lba;
      end
    end
  end

  AST_ONE_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chunk_done, chunk_park})); // R2
  AST_PARK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_park |-> !irq && !copy_valid && !cmd_illegal); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ack |=> req_valid && $stable(req_offset) && $stable(req_op) && $stable(req_len)); // R4
  AST_REQ_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(active)); // R4
  AST_ILLEGAL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_illegal |-> chunk_done && !req_valid && !irq); // R6
  AST_ERR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    drv_err |-> irq && chunk_done && !active); // R8
  AST_COPY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    copy_valid |-> irq && !req_valid); // R10
endmodule

// File: tb/ide_dma_seq_bench.sv
module ide_dma_seq_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 0, is_optical = 0, chunk_valid = 0, req_ack = 0, req_err = 0;
  logic [1:0]  cmd = 0;
  logic [31:0] sector_lba = 0;
  logic [15:0] sector_cnt = 0, chunk_len = 0;
  logic [27:0] pkt_size = 0;
  logic        kick, active, chunk_done, chunk_park, req_valid, copy_valid, irq, drv_err, cmd_illegal;
  logic [1:0]  req_op;
  logic [43:0] req_offset;
  logic [15:0] req_len, copy_len;
  logic [7:0]  drv_status;
  int checks = 0, errors = 0;

  ide_dma_seq u_ide_dma_seq (.*);

  always #4 clk = ~clk;

  localparam logic [31:0] V_LBA [5] = '{32'd5, 32'd100, 32'd7, 32'd0, 32'h00FFFFFF};
  localparam logic [15:0] V_CNT [5] = '{16'd1, 16'd2, 16'd1, 16'd4, 16'd3};
  localparam logic [1:0]  V_CMD [5] = '{2'd0, 2'd1, 2'd2, 2'd0, 2'd1};
  localparam logic [15:0] V_LEN [5] = '{16'd512, 16'd512, 16'd1024, 16'd256, 16'd1536};

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(input logic opt, input logic [31:0] lba, input logic [15:0] cnt,
                          input logic [27:0] pkt, input logic [1:0] c);
    is_optical = opt; sector_lba = lba; sector_cnt = cnt; pkt_size = pkt; cmd = c;
    start = 1; tick; start = 0;
  endtask

  task automatic send_chunk(input logic [15:0] len);
    chunk_valid = 1; chunk_len = len; tick; chunk_valid = 0;
  endtask

  task automatic answer(input logic err);
    req_ack = 1; req_err = err; tick; req_ack = 0; req_err = 0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick; tick; rst_n = 1; tick;
    chk("R12 active", active, 0);
    chk("R12 status", drv_status, 0);
    chk("R12 pulses", {kick, chunk_done, chunk_park, req_valid, irq, drv_err, cmd_illegal, copy_valid}, 0);

    send_chunk(16'd512);
    chk("R2 park", chunk_park, 1);
    chk("R2 no done", chunk_done, 0);
    chk("R2 no req", req_valid, 0);

    for (int i = 0; i < 5; i++) begin
      automatic bit fin = (longint'(V_LEN[i]) >= longint'(V_CNT[i]) * 512);
      do_start(0, V_LBA[i], V_CNT[i], 0, V_CMD[i]);
      chk("R1 kick", kick, 1);
      chk("R1 active", active, 1);
      send_chunk(V_LEN[i]);
      chk("R4 req", req_valid, 1);
      chk("R4 offset", req_offset, longint'(V_LBA[i]) * 512);
      chk("R4 len", req_len, V_LEN[i]);
      chk("R6 op", req_op, V_CMD[i]);
      answer(0);
      chk("R7 done", chunk_done, 1);
      chk("R7 irq", irq, fin);
      chk("R7 active", active, !fin);
      if (fin) chk("R7 status", drv_status, 8'h50);
    end

    do_start(0, 32'd3, 16'd4, 0, 2'd0);
    send_chunk(16'd512);  chk("R4 off0", req_offset, 1536); answer(0);
    chk("R4 mid irq", irq, 0);
    send_chunk(16'd300);  chk("R4 off1", req_offset, 2048); chk("R4 len1", req_len, 300); answer(0);
    send_chunk(16'd1236); chk("R4 off2", req_offset, 2348); answer(0);
    chk("R7 exact end irq", irq, 1);

    do_start(0, 32'd9, 16'd2, 0, 2'd0);
    send_chunk(16'd0);
    chk("R3 done", chunk_done, 1);
    chk("R3 irq", irq, 0);
    chk("R3 active", active, 1);
    chk("R3 req", req_valid, 0);

    do_start(0, 32'd9, 16'd0, 0, 2'd0);
    send_chunk(16'd512);
    chk("R9 done", chunk_done, 1);
    chk("R9 irq", irq, 1);
    chk("R9 status", drv_status, 8'h50);
    chk("R9 active", active, 0);
    chk("R9 req", req_valid, 0);

    do_start(1, 32'd10, 16'd0, 28'd4096, 2'd3);
    send_chunk(16'd2048);
    chk("R5 offset0", req_offset, 20480);
    chk("R5 op", req_op, 0);
    answer(0); chk("R5 mid irq", irq, 0);
    send_chunk(16'd2048);
    chk("R5 offset1", req_offset, 22528);
    answer(0); chk("R5 end irq", irq, 1);

    do_start(1, 32'hFFFFFFFF, 16'd0, 28'd100, 2'd0);
    send_chunk(16'd512);
    chk("R10 copy", copy_valid, 1);
    chk("R10 cap", copy_len, 100);
    chk("R10 irq", irq, 1);
    chk("R10 req", req_valid, 0);
    chk("R10 active", active, 0);
    do_start(1, 32'hFFFFFFFF, 16'd0, 28'd1000, 2'd0);
    send_chunk(16'd64);
    chk("R10 short", copy_len, 64);

    do_start(0, 32'd4, 16'd1, 0, 2'd3);
    send_chunk(16'd512);
    chk("R6 illegal", cmd_illegal, 1);
    chk("R6 done", chunk_done, 1);
    chk("R6 req", req_valid, 0);
    chk("R6 active", active, 0);

    do_start(0, 32'd4, 16'd2, 0, 2'd1);
    send_chunk(16'd512);
    answer(1);
    chk("R8 err", drv_err, 1);
    chk("R8 irq", irq, 1);
    chk("R8 status", drv_status, 8'h51);
    chk("R8 done", chunk_done, 1);
    chk("R8 active", active, 0);

    do_start(0, 32'd5, 16'd1, 0, 2'd0);
    send_chunk(16'd512);
    do_start(0, 32'd9, 16'd8, 0, 2'd0);
    chk("R11 busy start kick", kick, 0);
    answer(0);
    chk("R11 total kept", irq, 1);

    is_optical = 0; sector_lba = 32'd1; sector_cnt = 16'd1; cmd = 2'd0;
    start = 1; chunk_valid = 1; chunk_len = 16'd512; tick; start = 0; chunk_valid = 0;
    chk("R11 same park", chunk_park, 1);
    chk("R11 same kick", kick, 1);
    chk("R11 same active", active, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule